// File: doc/BRIEF.md
# Two-Dimensional Parity Block Codec

This block protects a block of six 7-bit data words with two crossing parity checks. The encoder side accepts the six data words one per handshake. It emits each word with an even-parity bit appended below its data bits. It then sends a seventh coded word that holds the column parity of the six coded words. The column parity covers the parity-bit column as well.

The decoder side accepts seven coded words and stores the whole block. It builds a row syndrome for every received word and a column syndrome for every bit position. When exactly one row and exactly one column fail, the bit where they cross is the flipped one. If that bit is a data bit, the decoder inverts it. After the block is stored, the decoder returns the six data words with two status flags. One flag reports a corrected error and the other reports an error it cannot correct. Both sides use a valid/ready handshake and move one word per cycle.

Top module: `p2d_codec`

## Requirements
- R1: Each of the first six coded words is `{data[6:0], p}`, where p (bit 0) is 1 exactly when the data word holds an odd number of ones. Every such coded word therefore has even parity over its 8 bits.
- R2: The seventh coded word of a block holds, in each bit position, the XOR of that position over the six preceding coded words. The encoder accepts no input while it offers this word. Example: the data rows 1011011, 1101011, 0011101, 1111000, 1000101 and 0101111 get parity bits 1,1,0,0,1,1, and the seventh word is 01111110.
- R3: A word moves only in a cycle where valid and ready are both high. An output word that is offered but not taken stays unchanged until it is taken.
- R4: The decoder raises no output valid until it has accepted all seven coded words of a block. While it offers output, its input ready is low.
- R5: If every row and column check passes, the decoder outputs the six data fields (bits 7:1) unchanged, with both flags low.
- R6: If exactly one row among the six data rows fails and exactly one column among the data bits 7:1 fails, the decoder inverts that bit in that word and raises the corrected flag.
- R7: If exactly one row and one column fail and they cross in the parity column (bit 0) or in the seventh word, the data is output unchanged and the corrected flag is raised.
- R8: Any other failing pattern, including every two-bit error, raises the uncorrectable flag and passes the received data fields through unchanged.
- R9: The two flags never rise together, and they hold the same value on all six output words of a block.
- R10: A synchronous active-high reset returns both sides to the start of a block. After reset the encoder's next output is the coded form of the next data word, and the decoder is ready to accept the first word of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Encoder data word offered |
| enc_in_ready | output | 1 | Encoder takes the offered data word |
| enc_in_data | input | 7 | Encoder data word |
| enc_out_valid | output | 1 | Encoder coded word offered |
| enc_out_ready | input | 1 | Downstream takes the coded word |
| enc_out_data | output | 8 | Coded word, parity bit at bit 0 |
| dec_in_valid | input | 1 | Decoder coded word offered |
| dec_in_ready | output | 1 | Decoder takes the coded word |
| dec_in_data | input | 8 | Received coded word |
| dec_out_valid | output | 1 | Decoded data word offered |
| dec_out_ready | input | 1 | Downstream takes the decoded word |
| dec_out_data | output | 7 | Decoded (possibly corrected) data word |
| dec_out_corrected | output | 1 | A single error was located in this block |
| dec_out_uncorrectable | output | 1 | The failure pattern could not be corrected |

## Verification
The encoder passes its input straight through during the data phase. The hold-stable check on the coded output therefore assumes that upstream holds an offered data word steady until it is taken. The bench honours this because it advances its input index only after a completed handshake. The flag checks assume that each block contains no more than two flipped bits, because three or more flips can look like a single error. The bench injects zero, one or two flips at distinct positions and never more. The decoder assertions also assume that a block reaches the decoder whole. The bench always sends exactly seven words between resets, except in the test of a reset in the middle of a block.

// File: rtl/p2d_pkg.sv
package p2d_pkg;

  // Decoder phase: gathering a block, or returning its data words
  typedef enum logic {
    DEC_GATHER = 1'b0,
    DEC_RETURN = 1'b1
  } dec_phase_t;

  // Verdict on one received block
  typedef struct packed {
    logic fixed;
    logic broken;
  } blk_verdict_t;

endpackage

// File: rtl/p2d_encoder.sv
module p2d_encoder #(
  parameter int DATA_W = 7,
  parameter int ROWS   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W:0]   out_data
);
  localparam int CW    = DATA_W + 1;
  localparam int CNT_W = $clog2(ROWS + 1);

  // Even-fill bit: 1 when the word holds an odd count of ones
  function automatic logic fill_bit(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction

  logic [CNT_W-1:0] word_idx;
  logic [CW-1:0]    col_acc;
  logic [CW-1:0]    coded_word;
  logic             par_phase;
  logic             word_fire;

  assign par_phase  = (word_idx == CNT_W'(ROWS));
  assign coded_word = {in_data, fill_bit(in_data)};
  assign out_valid  = par_phase ? 1'b1 : in_valid;
  assign out_data   = par_phase ? col_acc : coded_word;
  assign in_ready   = par_phase ? 1'b0 : out_ready;
  assign word_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_idx <= '0;
      col_acc  <= '0;
    end else if (word_fire) begin
      if (par_phase) begin
        word_idx <= '0;
        col_acc  <= '0;
      end else begin
        word_idx <= word_idx + 1'b1;
        col_acc  <= col_acc ^ coded_word;
      end
    end
  end

  // R2
  parity_word_even_chk: assert property (@(posedge clk) disable iff (rst)
    (par_phase && out_valid) |-> (^out_data == 1'b0));

  // R3
  parity_word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (par_phase && !out_ready) |=> (par_phase && $stable(out_data)));

endmodule

// File: rtl/p2d_locator.sv
module p2d_locator #(
  parameter int DATA_W = 7,
  parameter int ROWS   = 6
) (
  input  logic [ROWS:0]     row_syn,
  input  logic [DATA_W:0]   col_syn,
  output logic              fixed,
  output logic              broken,
  output logic [ROWS-1:0]   row_hit,
  output logic [DATA_W-1:0] data_mask
);
  // Exactly one bit set, row-syndrome width
  function automatic logic single_row(input logic [ROWS:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction

  // Exactly one bit set, column-syndrome width
  function automatic logic single_col(input logic [DATA_W:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction

  logic clean;
  logic one_cross;

  assign clean     = (row_syn == '0) && (col_syn == '0);
  assign one_cross = single_row(row_syn) && single_col(col_syn);
  assign fixed     = one_cross;
  assign broken    = !clean && !one_cross;
  // A crossing in the seventh word or in bit 0 leaves the mask or hit empty
  assign row_hit   = one_cross ? row_syn[ROWS-1:0] : '0;
  assign data_mask = one_cross ? col_syn[DATA_W:1] : '0;

endmodule

// File: rtl/p2d_decoder.sv
module p2d_decoder
  import p2d_pkg::*;
#(
  parameter int DATA_W = 7,
  parameter int ROWS   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W:0]   in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fixed,
  output logic              out_broken
);
  localparam int CW     = DATA_W + 1;
  localparam int BLK    = ROWS + 1;
  localparam int LD_W   = $clog2(BLK);
  localparam int EM_W   = (ROWS > 1) ? $clog2(ROWS) : 1;

  function automatic logic word_odd(input logic [CW-1:0] w);
    return ^w;
  endfunction

  dec_phase_t     phase;
  logic [LD_W-1:0] ld_idx;
  logic [EM_W-1:0] em_idx;
  logic [CW-1:0]   blk_mem [BLK];
  logic [ROWS:0]   row_syn;
  logic [CW-1:0]   col_syn;
  logic            in_fire;
  logic            out_fire;
  logic            last_in;
  logic            last_out;
  blk_verdict_t    verdict;
  logic [ROWS-1:0] row_hit;
  logic [DATA_W-1:0] data_mask;
  logic [CW-1:0]   cur_word;
  logic [DATA_W-1:0] raw_data;
  logic            fix_here;

  p2d_locator #(.DATA_W(DATA_W), .ROWS(ROWS)) u_loc (
    .row_syn   (row_syn),
    .col_syn   (col_syn),
    .fixed     (verdict.fixed),
    .broken    (verdict.broken),
    .row_hit   (row_hit),
    .data_mask (data_mask)
  );

  assign in_ready   = (phase == DEC_GATHER);
  assign out_valid  = (phase == DEC_RETURN);
  assign in_fire    = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;
  assign last_in    = (ld_idx == LD_W'(BLK - 1));
  assign last_out   = (em_idx == EM_W'(ROWS - 1));
  assign cur_word   = blk_mem[em_idx];
  assign raw_data   = cur_word[CW-1:1];
  assign fix_here   = row_hit[em_idx];
  assign out_data   = raw_data ^ (fix_here ? data_mask : '0);
  assign out_fixed  = verdict.fixed;
  assign out_broken = verdict.broken;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= DEC_GATHER;
      ld_idx  <= '0;
      em_idx  <= '0;
      row_syn <= '0;
      col_syn <= '0;
    end else if (phase == DEC_GATHER) begin
      if (in_fire) begin
        blk_mem[ld_idx] <= in_data;
        row_syn[ld_idx] <= word_odd(in_data);
        col_syn         <= col_syn ^ in_data;
        if (last_in) begin
          ld_idx <= '0;
          phase  <= DEC_RETURN;
        end else begin
          ld_idx <= ld_idx + 1'b1;
        end
      end
    end else if (out_fire) begin
      if (last_out) begin
        em_idx  <= '0;
        row_syn <= '0;
        col_syn <= '0;
        phase   <= DEC_GATHER;
      end else begin
        em_idx <= em_idx + 1'b1;
      end
    end
  end

  // R4
  return_after_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_fire && last_in));

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_fixed && out_broken));

  // R9
  flags_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> $stable({out_fixed, out_broken}));

  // R8
  passthrough_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fixed) |-> (out_data == raw_data));

endmodule

// File: rtl/p2d_codec.sv
module p2d_codec #(
  parameter int DATA_W = 7,
  parameter int ROWS   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [DATA_W-1:0] enc_in_data,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [DATA_W:0]   enc_out_data,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [DATA_W:0]   dec_in_data,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [DATA_W-1:0] dec_out_data,
  output logic              dec_out_corrected,
  output logic              dec_out_uncorrectable
);

  p2d_encoder #(.DATA_W(DATA_W), .ROWS(ROWS)) u_enc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   (enc_in_data),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_out_data)
  );

  p2d_decoder #(.DATA_W(DATA_W), .ROWS(ROWS)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (dec_in_valid),
    .in_ready   (dec_in_ready),
    .in_data    (dec_in_data),
    .out_valid  (dec_out_valid),
    .out_ready  (dec_out_ready),
    .out_data   (dec_out_data),
    .out_fixed  (dec_out_corrected),
    .out_broken (dec_out_uncorrectable)
  );

endmodule

// File: tb/tb_p2d_codec.sv
module tb_p2d_codec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_in_valid = 1'b0, enc_out_ready = 1'b0;
  logic [6:0] enc_in_data = '0;
  logic       enc_in_ready, enc_out_valid;
  logic [7:0] enc_out_data;
  logic       dec_in_valid = 1'b0, dec_out_ready = 1'b0;
  logic [7:0] dec_in_data = '0;
  logic       dec_in_ready, dec_out_valid, dec_out_corrected, dec_out_uncorrectable;
  logic [6:0] dec_out_data;

  int total = 0;
  int bad = 0;

  logic [6:0] blk_d [6];
  logic [7:0] blk_c [7];
  logic [7:0] blk_r [7];
  logic [6:0] exp_d [6];
  logic       exp_corr, exp_unc;
  string      exp_tag;
  logic [7:0] enc_q [$];

  always #2 clk = ~clk;

  p2d_codec dut (
    .clk(clk), .rst(rst),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_data(enc_in_data),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_data(enc_out_data),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_in_data(dec_in_data),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready), .dec_out_data(dec_out_data),
    .dec_out_corrected(dec_out_corrected), .dec_out_uncorrectable(dec_out_uncorrectable)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Reference: count ones the long way
  function automatic int ones7(input logic [6:0] d);
    int n = 0;
    for (int b = 0; b < 7; b++) n += d[b];
    return n;
  endfunction

  task automatic model_encode();
    enc_q.delete();
    for (int r = 0; r < 6; r++) enc_q.push_back({blk_d[r], 1'(ones7(blk_d[r]) % 2)});
    begin
      logic [7:0] colw;
      for (int b = 0; b < 8; b++) begin
        int n = 0;
        for (int r = 0; r < 6; r++) n += enc_q[r][b];
        colw[b] = 1'(n % 2);
      end
      enc_q.push_back(colw);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    enc_in_valid = 0; dec_in_valid = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_enc(input bit stalls);
    int ii = 0;
    int oo = 0;
    logic stalled = 0;
    logic [7:0] prev = '0;
    model_encode();
    while (oo < 7) begin
      @(negedge clk);
      enc_in_valid  = (ii < 6);
      enc_in_data   = (ii < 6) ? blk_d[ii] : 7'h0;
      enc_out_ready = stalls ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (stalled) chk(enc_out_data == prev, "R3 hold", enc_out_data, prev);
      if (oo == 6 && enc_out_valid) chk(!enc_in_ready, "R2 no input", enc_in_ready, 0);
      if (enc_out_valid && enc_out_ready) begin
        logic [7:0] e;
        e = enc_q.pop_front();
        blk_c[oo] = enc_out_data;
        chk(enc_out_data == e, (oo < 6) ? "R1 coded word" : "R2 column word", enc_out_data, e);
        oo++;
      end
      stalled = enc_out_valid && !enc_out_ready;
      prev    = enc_out_data;
      if (enc_in_valid && enc_in_ready) ii++;
    end
    @(negedge clk);
    enc_in_valid = 0;
    enc_out_ready = 0;
  endtask

  task automatic run_dec(input bit stalls);
    int ii = 0;
    int oo = 0;
    logic stalled = 0;
    logic [6:0] prev = '0;
    dec_out_ready = 1'b1;
    while (ii < 7) begin
      @(negedge clk);
      dec_in_valid = stalls ? ($urandom % 2 == 0) : 1'b1;
      dec_in_data  = blk_r[ii];
      #1;
      chk(!dec_out_valid, "R4 no early output", dec_out_valid, 0);
      if (dec_in_valid && dec_in_ready) ii++;
    end
    while (oo < 6) begin
      @(negedge clk);
      dec_in_valid  = 1'b0;
      dec_out_ready = stalls ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (stalled) chk(dec_out_data == prev, "R3 hold", dec_out_data, prev);
      if (dec_out_valid) begin
        chk(!dec_in_ready, "R4 ready low", dec_in_ready, 0);
        chk(!(dec_out_corrected && dec_out_uncorrectable), "R9 exclusive",
            {dec_out_corrected, dec_out_uncorrectable}, 0);
      end
      if (dec_out_valid && dec_out_ready) begin
        chk(dec_out_data == exp_d[oo], exp_tag, dec_out_data, exp_d[oo]);
        chk({dec_out_corrected, dec_out_uncorrectable} == {exp_corr, exp_unc},
            {exp_tag, " R9 flags"}, {dec_out_corrected, dec_out_uncorrectable}, {exp_corr, exp_unc});
        oo++;
      end
      stalled = dec_out_valid && !dec_out_ready;
      prev    = dec_out_data;
    end
    @(negedge clk);
    dec_out_ready = 0;
  endtask

  // Inject nf flips (0..2) at (r0,c0),(r1,c1); c is bit index, 0 = parity bit
  task automatic do_case(input int nf, input int r0, input int c0, input int r1, input int c1, input bit stalls);
    for (int r = 0; r < 7; r++) blk_r[r] = blk_c[r];
    if (nf >= 1) blk_r[r0][c0] = ~blk_r[r0][c0];
    if (nf >= 2) blk_r[r1][c1] = ~blk_r[r1][c1];
    exp_corr = (nf == 1);
    exp_unc  = (nf == 2);
    for (int r = 0; r < 6; r++) exp_d[r] = (nf == 2) ? blk_r[r][7:1] : blk_d[r];
    if (nf == 0) exp_tag = "R5 clean";
    else if (nf == 1) exp_tag = (r0 < 6 && c0 >= 1) ? "R6 data fix" : "R7 check-bit fix";
    else exp_tag = "R8 uncorrectable";
    run_dec(stalls);
  endtask

  task automatic rand_block();
    for (int r = 0; r < 6; r++) blk_d[r] = 7'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    enc_out_ready = 1'b1;
    #1;
    // R10
    chk(!dec_out_valid, "R10 dec idle", dec_out_valid, 0);
    chk(dec_in_ready, "R10 dec ready", dec_in_ready, 1);
    chk(!enc_out_valid && enc_in_ready, "R10 enc start", {enc_out_valid, enc_in_ready}, 2'b01);
    enc_out_ready = 1'b0;

    // R2 worked example
    blk_d[0] = 7'b1011011; blk_d[1] = 7'b1101011; blk_d[2] = 7'b0011101;
    blk_d[3] = 7'b1111000; blk_d[4] = 7'b1000101; blk_d[5] = 7'b0101111;
    run_enc(1'b0);
    chk(blk_c[6] == 8'b01111110, "R2 example column word", blk_c[6], 8'b01111110);
    chk({blk_c[0][0], blk_c[1][0], blk_c[2][0], blk_c[3][0], blk_c[4][0], blk_c[5][0]} == 6'b110011,
        "R1 example parity bits",
        {blk_c[0][0], blk_c[1][0], blk_c[2][0], blk_c[3][0], blk_c[4][0], blk_c[5][0]}, 6'b110011);

    // Directed decoder cases
    do_case(0, 0, 0, 0, 0, 1'b0);
    do_case(1, 2, 5, 0, 0, 1'b0);   // R6
    do_case(1, 4, 0, 0, 0, 1'b0);   // R7 parity column
    do_case(1, 6, 3, 0, 0, 1'b0);   // R7 seventh word
    do_case(1, 6, 0, 0, 0, 1'b0);   // R7 corner
    do_case(2, 1, 2, 1, 6, 1'b0);   // R8 same row
    do_case(2, 0, 4, 5, 4, 1'b0);   // R8 same column
    do_case(2, 0, 1, 3, 7, 1'b1);   // R8 diagonal

    // R10: reset in the middle of a block on both sides
    @(negedge clk);
    enc_out_ready = 1'b1;
    enc_in_valid  = 1'b1;
    enc_in_data   = 7'h55;
    repeat (3) @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_data  = 8'hA5;
    repeat (4) @(negedge clk);
    do_reset();
    rand_block();
    run_enc(1'b0);
    do_case(1, 3, 3, 0, 0, 1'b0);

    // Random blocks with stalls
    for (int k = 0; k < 80; k++) begin
      int nf, r0, c0, r1, c1;
      rand_block();
      run_enc(1'b1);
      nf = $urandom % 3;
      r0 = $urandom % 7; c0 = $urandom % 8;
      r1 = $urandom % 7; c1 = $urandom % 8;
      while (r1 == r0 && c1 == c0) begin
        r1 = $urandom % 7; c1 = $urandom % 8;
      end
      do_case(nf, r0, c0, r1, c1, 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule